// File: doc/BRIEF.md
# Interlace-Aware Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel pixel output, together with flags that name the field parity and the stereo view being scanned. Every line is laid out as sync pulse, back porch, active pixels and then front porch. Every field is built the same way, counted in lines. The horizontal fields are shared by all fields. The vertical sync, back porch and front porch come from one of four separate sets, chosen by field parity (odd or even) and view (left or right). Each set can also delay its vertical sync by half a line period, which is how the even field of an interlaced picture is marked.

In progressive mode only the left-odd set is used. The interlace enable alternates odd and even fields, and the programmed active height is then one field. The stereo enable alternates the left and right views. With both enables set the block cycles through all four sets. Each of the three strobes and the forwarded pixel clock has its own polarity-invert bit. A soft reset, or a cleared enable, holds the block idle. Configuration is taken in while the block is idle and at each field boundary, so a write made in the middle of a field does not disturb that field.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts h_sync_len + h_back_len + h_active_len + h_front_len pixel clocks. The horizontal sync is active for the first h_sync_len clocks of every line.
- R2: de is active only on active lines (field lines h-independent from v_sync_len + v_back_len up to v_active_len lines later) and only for the h_active_len clocks after sync and back porch, giving v_active_len de pulses per field.
- R3: A field lasts v_sync_len + v_back_len + v_active_len + v_front_len lines of the current set. Vertical sync is active for v_sync_len lines (v_sync_len × line length clocks).
- R4: When a set's half-shift bit is set, its vertical sync starts and ends floor(line length / 2) clocks after a line start instead of at the line start. That set must have a back porch of at least one line.
- R5: Sets are indexed {view, field}: index bit 0 is 1 for an even field and bit 1 is 1 for the right view. Field order is: progressive 0,0,…; interlace 0,1,0,1; stereo 0,2,0,2; interlace with stereo 0,2,1,3 and then repeating.
- R6: field_o (index bit 0) and view_o (index bit 1) change only on the first clock of a field. Throughout each vertical sync they show the index of the set that field uses.
- R7: pol_inv bit 0 inverts hsync_o, bit 1 inverts vsync_o and bit 2 inverts de_o. A cleared bit gives active-high strobes.
- R8: pclk_o follows clk when pol_inv bit 3 is clear and is the inverse of clk when it is set.
- R9: While soft_rst is high or enable is low, all three strobes are inactive. The first clock after release starts line 0 of a left-odd field, with hsync and vsync both starting on that clock.
- R10: All configuration inputs are captured while idle and at the end of each field. A change made during a field takes effect from the next field.
- R11: With rst_n low at a clock edge, the strobes go inactive and field_o and view_o go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Holds the generator idle while high |
| enable | input | 1 | Runs the generator while high |
| h_sync_len | input | HCW | Horizontal sync width in clocks |
| h_back_len | input | HCW | Horizontal back porch in clocks |
| h_active_len | input | HCW | Active pixels per line |
| h_front_len | input | HCW | Horizontal front porch in clocks |
| v_active_len | input | VCW | Active lines per field |
| v_sync_len | input | 4×VCW | Vertical sync lines, one entry per set |
| v_back_len | input | 4×VCW | Vertical back porch lines, per set |
| v_front_len | input | 4×VCW | Vertical front porch lines, per set |
| v_half_shift | input | 4 | Half-line vsync delay, one bit per set |
| interlace_en | input | 1 | Alternate odd and even fields |
| stereo_en | input | 1 | Alternate left and right views |
| pol_inv | input | 4 | Invert bits: hsync, vsync, de, pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Forwarded pixel clock |
| field_o | output | 1 | 1 during an even field |
| view_o | output | 1 | 1 during a right-view field |

## Verification
The bench aims at the phase of each vertical sync edge relative to the line start. A generator that ignores the half-line bit, or applies it to the wrong set, shows its vsync edge 8 clocks off and a field period that differs by the same amount. It walks all four field orders and checks the flags at every vsync. A wrong next-set rule shows up as a flag mismatch on the second or third field. A mid-field change of the horizontal sync width is applied while the block runs, to catch a design that takes configuration outside the field boundary, which would widen a pulse too early. Idle levels are checked with polarity inversion on, which exposes an inversion applied before the idle gating or not applied at all.

// File: rtl/rtg_pkg.sv
// Shared widths and the captured-configuration record of the raster timing generator.
// Assumes four vertical sets, indexed {view, field}.
package rtg_pkg;
    parameter int unsigned HCW  = 12;          // horizontal field width
    parameter int unsigned VCW  = 11;          // vertical field width
    parameter int unsigned NSET = 4;           // vertical timing sets
    localparam int unsigned HTW = HCW + 2;     // horizontal counter width
    localparam int unsigned VTW = VCW + 2;     // line counter width
    localparam int unsigned SIW = $clog2(NSET);

    typedef struct packed {
        logic [HCW-1:0]            hs;
        logic [HCW-1:0]            hb;
        logic [HCW-1:0]            ha;
        logic [HCW-1:0]            hf;
        logic [VCW-1:0]            va;
        logic [NSET-1:0][VCW-1:0]  vs;
        logic [NSET-1:0][VCW-1:0]  vb;
        logic [NSET-1:0][VCW-1:0]  vf;
        logic [NSET-1:0]           half;
        logic                      intl;
        logic                      stereo;
        logic [3:0]                pol;
    } tcfg_t;
endpackage

// File: rtl/rtg_hcount.sv
// Pixel counter within a line. Produces the line end, the horizontal
// sync window, the active-column window and the half-line point.
// Assumes the line total is at least 2 clocks.
module rtg_hcount
    import rtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic [HCW-1:0] hs,
    input  logic [HCW-1:0] hb,
    input  logic [HCW-1:0] ha,
    input  logic [HCW-1:0] hf,
    output logic [HTW-1:0] hcnt,
    output logic [HTW-1:0] half_pt,
    output logic           line_end,
    output logic           hs_raw,
    output logic           de_col
);
    logic [HTW-1:0] htotal;
    logic [HTW-1:0] act_lo;

    // line geometry from the captured fields
    always_comb begin
        htotal  = HTW'(hs) + HTW'(hb) + HTW'(ha) + HTW'(hf);
        act_lo  = HTW'(hs) + HTW'(hb);
        half_pt = htotal >> 1;
    end

    // windows within the line
    always_comb begin
        line_end = step && (hcnt == htotal - 1'b1);
        hs_raw   = step && (hcnt < HTW'(hs));
        de_col   = (hcnt >= act_lo) && (hcnt < act_lo + HTW'(ha));
    end

    // advance the pixel counter, wrapping at the line end
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
        end else if (step) begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtg_vseq.sv
// Line counter and field sequencer. Selects one of four vertical sets by
// {view, field}, builds the vertical sync (with optional half-line delay)
// and the active-row window, and moves to the next set at each field end.
// Assumes every set has a sync of at least one line.
module rtg_vseq
    import rtg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic                     line_end,
    input  logic [HTW-1:0]           hcnt,
    input  logic [HTW-1:0]           half_pt,
    input  logic [VCW-1:0]           va,
    input  logic [NSET-1:0][VCW-1:0] vs,
    input  logic [NSET-1:0][VCW-1:0] vb,
    input  logic [NSET-1:0][VCW-1:0] vf,
    input  logic [NSET-1:0]          half,
    input  logic                     intl,
    input  logic                     stereo,
    output logic [SIW-1:0]           set_idx,
    output logic                     vs_raw,
    output logic                     de_row,
    output logic                     field_end,
    output logic                     field_start
);
    logic [NSET-1:0][VTW-1:0] tot;
    logic [NSET-1:0][VTW-1:0] row_lo;
    logic [VTW-1:0]           vcnt;
    logic [VTW-1:0]           cur_vs;
    logic [SIW-1:0]           nxt_idx;
    logic                     hi_half;
    logic                     vs_on;

    // per-set field length and first active line
    for (genvar g = 0; g < NSET; g++) begin : g_set
        assign tot[g]    = VTW'(vs[g]) + VTW'(vb[g]) + VTW'(va) + VTW'(vf[g]);
        assign row_lo[g] = VTW'(vs[g]) + VTW'(vb[g]);
    end

    // next set: stereo toggles the view, interlace toggles the field after each view pair
    always_comb begin
        nxt_idx[1] = stereo & ~set_idx[1];
        nxt_idx[0] = intl & (stereo ? (set_idx[0] ^ set_idx[1]) : ~set_idx[0]);
    end

    // vertical sync window, delayed by half a line for shifted sets
    always_comb begin
        cur_vs  = VTW'(vs[set_idx]);
        hi_half = hcnt >= half_pt;
        if (half[set_idx]) begin
            vs_on = ((vcnt == '0) && hi_half) ||
                    ((vcnt != '0) && (vcnt < cur_vs)) ||
                    ((vcnt == cur_vs) && !hi_half);
        end else begin
            vs_on = vcnt < cur_vs;
        end
        vs_raw      = step && vs_on;
        de_row      = (vcnt >= row_lo[set_idx]) && (vcnt < row_lo[set_idx] + VTW'(va));
        field_end   = line_end && (vcnt == tot[set_idx] - 1'b1);
        field_start = step && (vcnt == '0) && (hcnt == '0);
    end

    // advance the line counter and the set index
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vcnt    <= '0;
            set_idx <= '0;
        end else if (field_end) begin
            vcnt    <= '0;
            set_idx <= nxt_idx;
        end else if (line_end) begin
            vcnt    <= vcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtg_polar.sv
// Output polarity stage: one invert bit per strobe plus the forwarded clock.
// Assumes the raw strobes are active-high.
module rtg_polar #(
    parameter int unsigned NSIG = 3
) (
    input  logic            clk,
    input  logic [NSIG-1:0] raw,
    input  logic [NSIG:0]   inv,
    output logic [NSIG-1:0] pin,
    output logic            pclk
);
    // per-strobe invert
    for (genvar g = 0; g < NSIG; g++) begin : g_pol
        assign pin[g] = raw[g] ^ inv[g];
    end

    // forwarded pixel clock with its own invert
    assign pclk = clk ^ inv[NSIG];
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator. Captures configuration while idle
// and at each field end, runs the pixel and line counters while enabled
// and out of soft reset, and drives the polarised strobes and flags.
// Assumes configuration is static for at least one clock before release.
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     enable,
    input  logic [HCW-1:0]           h_sync_len,
    input  logic [HCW-1:0]           h_back_len,
    input  logic [HCW-1:0]           h_active_len,
    input  logic [HCW-1:0]           h_front_len,
    input  logic [VCW-1:0]           v_active_len,
    input  logic [NSET-1:0][VCW-1:0] v_sync_len,
    input  logic [NSET-1:0][VCW-1:0] v_back_len,
    input  logic [NSET-1:0][VCW-1:0] v_front_len,
    input  logic [NSET-1:0]          v_half_shift,
    input  logic                     interlace_en,
    input  logic                     stereo_en,
    input  logic [3:0]               pol_inv,
    output logic                     hsync_o,
    output logic                     vsync_o,
    output logic                     de_o,
    output logic                     pclk_o,
    output logic                     field_o,
    output logic                     view_o
);
    tcfg_t          cfg_d;
    tcfg_t          cfg_q;
    logic           run_req;
    logic           run_q;
    logic           cfg_load;
    logic [HTW-1:0] hcnt;
    logic [HTW-1:0] half_pt;
    logic           line_end;
    logic           hs_raw;
    logic           de_col;
    logic           vs_raw;
    logic           de_row;
    logic           de_raw;
    logic           field_end;
    logic           field_start;
    logic [SIW-1:0] set_idx;
    logic [2:0]     pins;

    // gather the configuration inputs into one record
    always_comb begin
        cfg_d.hs     = h_sync_len;
        cfg_d.hb     = h_back_len;
        cfg_d.ha     = h_active_len;
        cfg_d.hf     = h_front_len;
        cfg_d.va     = v_active_len;
        cfg_d.vs     = v_sync_len;
        cfg_d.vb     = v_back_len;
        cfg_d.vf     = v_front_len;
        cfg_d.half   = v_half_shift;
        cfg_d.intl   = interlace_en;
        cfg_d.stereo = stereo_en;
        cfg_d.pol    = pol_inv;
    end

    assign run_req  = enable && !soft_rst;
    assign cfg_load = !run_q || field_end;

    // run state: one clock behind the request so counting starts at zero
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_req;
    end

    // configuration capture while idle and at field boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_load) cfg_q <= cfg_d;
    end

    rtg_hcount u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run_req),
        .step     (run_q),
        .hs       (cfg_q.hs),
        .hb       (cfg_q.hb),
        .ha       (cfg_q.ha),
        .hf       (cfg_q.hf),
        .hcnt     (hcnt),
        .half_pt  (half_pt),
        .line_end (line_end),
        .hs_raw   (hs_raw),
        .de_col   (de_col)
    );

    rtg_vseq u_vseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!run_req),
        .step        (run_q),
        .line_end    (line_end),
        .hcnt        (hcnt),
        .half_pt     (half_pt),
        .va          (cfg_q.va),
        .vs          (cfg_q.vs),
        .vb          (cfg_q.vb),
        .vf          (cfg_q.vf),
        .half        (cfg_q.half),
        .intl        (cfg_q.intl),
        .stereo      (cfg_q.stereo),
        .set_idx     (set_idx),
        .vs_raw      (vs_raw),
        .de_row      (de_row),
        .field_end   (field_end),
        .field_start (field_start)
    );

    assign de_raw = run_q && de_col && de_row;

    rtg_polar #(.NSIG(3)) u_polar (
        .clk  (clk),
        .raw  ({de_raw, vs_raw, hs_raw}),
        .inv  (cfg_q.pol),
        .pin  (pins),
        .pclk (pclk_o)
    );

    assign hsync_o = pins[0];
    assign vsync_o = pins[1];
    assign de_o    = pins[2];
    assign field_o = set_idx[0];
    assign view_o  = set_idx[1];
endmodule

// File: rtl/rtg_checker.sv
// Protocol checks for the raster timing generator, bound into its top.
// Assumes the configurations it sees are legal (sync and back porch of at least one line).
module rtg_checker
    import rtg_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           run_q,
    input logic           hs_raw,
    input logic           vs_raw,
    input logic           de_raw,
    input logic           line_end,
    input logic [HTW-1:0] hcnt,
    input logic           field_start,
    input logic           field_end,
    input logic [SIW-1:0] set_idx,
    input tcfg_t          cfg_q
);
    // idle means quiet strobes
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!hs_raw && !vs_raw && !de_raw))
        else $error("idle strobe active");

    // data enable never overlaps either sync
    p_de_outside_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (!hs_raw && !vs_raw))
        else $error("de during sync");

    // the pixel counter restarts after a line end
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && run_q) |=> (hcnt == '0))
        else $error("line did not wrap");

    // flags move only at the first clock of a field
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !field_start) |-> $stable(set_idx))
        else $error("flags moved mid-field");

    // captured configuration is frozen inside a running field
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !field_end) |=> $stable(cfg_q))
        else $error("configuration changed mid-field");
endmodule

bind raster_timing_gen rtg_checker u_rtg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_q       (run_q),
    .hs_raw      (hs_raw),
    .vs_raw      (vs_raw),
    .de_raw      (de_raw),
    .line_end    (line_end),
    .hcnt        (hcnt),
    .field_start (field_start),
    .field_end   (field_end),
    .set_idx     (set_idx),
    .cfg_q       (cfg_q)
);

// File: tb/test_raster_timing_gen.sv
// Self-checking bench: walks a table of modes, then directed tests.
module test_raster_timing_gen;
    import rtg_pkg::*;

    logic clk = 1'b0;
    logic rst_n, soft_rst, enable;
    logic [HCW-1:0] h_sync_len, h_back_len, h_active_len, h_front_len;
    logic [VCW-1:0] v_active_len;
    logic [NSET-1:0][VCW-1:0] v_sync_len, v_back_len, v_front_len;
    logic [NSET-1:0] v_half_shift;
    logic interlace_en, stereo_en;
    logic [3:0] pol_inv;
    logic hsync_o, vsync_o, de_o, pclk_o, field_o, view_o;

    always #4 clk = ~clk; // 125 MHz

    raster_timing_gen i_raster_timing_gen (.*);

    // mode table: [13] interlace, [12] stereo, [11:8] pol_inv, [7:0] four set indices (field k in bits 2k+1:2k)
    localparam logic [13:0] MODES [5] = '{
        {1'b0, 1'b0, 4'b0000, 8'h00},
        {1'b1, 1'b0, 4'b0000, 8'h44},
        {1'b0, 1'b1, 4'b0000, 8'h88},
        {1'b1, 1'b1, 4'b0000, 8'hD8},
        {1'b0, 1'b0, 4'b1111, 8'h00}
    };
    localparam int VS_OF [4] = '{2, 3, 1, 2};
    localparam int VB_OF [4] = '{2, 1, 3, 2};
    localparam int VF_OF [4] = '{1, 2, 1, 1};
    localparam int HF_OF [4] = '{0, 1, 0, 1};
    localparam int VA = 4, HS = 2, HB = 3, HA = 8, HF = 3, HTOT = 16;

    int checks = 0, fails = 0;

    // monitor state (normalised to active-high using the programmed polarity)
    int cyc = 0, since_hs = 0, hs_run = 0, de_run = 0, vs_run = 0;
    int last_hs_w = 0, last_de_w = 0, last_vs_w = 0, hs_period = 0, last_hs_rise = 0;
    int hs_rises = 0, hs_falls = 0, vs_falls = 0, de_cnt = 0, de_prev_field = 0;
    int vs_phase = 0, vs_period = 0, last_vs_rise = 0;
    logic [1:0] rise_flags = 2'b00;
    logic p_hs = 0, p_vs = 0, p_de = 0;

    function automatic int lines_of(input int s);
        return VS_OF[s] + VB_OF[s] + VA + VF_OF[s];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic n_hs, n_vs, n_de;
        n_hs = hsync_o ^ pol_inv[0];
        n_vs = vsync_o ^ pol_inv[1];
        n_de = de_o ^ pol_inv[2];
        if (n_hs && !p_hs) begin
            since_hs = 0; hs_rises++; hs_period = cyc - last_hs_rise; last_hs_rise = cyc; hs_run = 1;
        end else begin
            since_hs++;
            if (n_hs) hs_run++;
            else if (p_hs) begin last_hs_w = hs_run; hs_falls++; end
        end
        if (n_de) de_run = p_de ? de_run + 1 : 1;
        else if (p_de) begin last_de_w = de_run; de_cnt++; end
        if (n_vs && !p_vs) begin
            vs_phase = since_hs; rise_flags = {view_o, field_o};
            vs_period = cyc - last_vs_rise; last_vs_rise = cyc;
            de_prev_field = de_cnt; de_cnt = 0; vs_run = 1;
        end else if (n_vs) vs_run++;
        else if (p_vs) begin last_vs_w = vs_run; vs_falls++; end
        p_hs = n_hs; p_vs = n_vs; p_de = n_de; cyc++;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic run_mode(input logic [13:0] v);
        int base;
        @(negedge clk);
        soft_rst = 1'b1; interlace_en = v[13]; stereo_en = v[12]; pol_inv = v[11:8];
        repeat (4) @(negedge clk);
        #2;
        chk("R9/R7 idle hsync", hsync_o, v[8]);
        chk("R9/R7 idle vsync", vsync_o, v[9]);
        chk("R9/R7 idle de", de_o, v[10]);
        chk("R8 pclk low phase", pclk_o, v[11]);
        base = vs_falls;
        @(negedge clk);
        soft_rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            int c, p;
            c = int'(v[2*(k%4) +: 2]);
            p = int'(v[2*((k+3)%4) +: 2]);
            while (vs_falls <= base + k) @(posedge clk);
            chk("R5/R6 set flags", int'(rise_flags), c);
            chk("R4 vsync phase", vs_phase, HF_OF[c] * (HTOT / 2));
            chk("R3 vsync width", last_vs_w, VS_OF[c] * HTOT);
            chk("R1 hsync width", last_hs_w, HS);
            chk("R1 line period", hs_period, HTOT);
            if (k > 0) begin
                chk("R2 de pulses", de_prev_field, VA);
                chk("R2 de width", last_de_w, HA);
                chk("R3 field period", vs_period,
                    lines_of(p) * HTOT + HF_OF[c] * (HTOT / 2) - HF_OF[p] * (HTOT / 2));
            end
        end
    endtask

    initial begin : stim
        int b;
        rst_n = 1'b0; soft_rst = 1'b0; enable = 1'b1;
        h_sync_len = HCW'(HS); h_back_len = HCW'(HB); h_active_len = HCW'(HA); h_front_len = HCW'(HF);
        v_active_len = VCW'(VA);
        for (int s = 0; s < 4; s++) begin
            v_sync_len[s] = VCW'(VS_OF[s]); v_back_len[s] = VCW'(VB_OF[s]);
            v_front_len[s] = VCW'(VF_OF[s]); v_half_shift[s] = HF_OF[s][0];
        end
        interlace_en = 1'b0; stereo_en = 1'b0; pol_inv = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R11 reset hsync", hsync_o, 0);
        chk("R11 reset vsync", vsync_o, 0);
        chk("R11 reset de", de_o, 0);
        chk("R11 reset field", field_o, 0);
        chk("R11 reset view", view_o, 0);
        enable = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        b = hs_rises;
        repeat (40) @(negedge clk);
        chk("R9 disabled stays quiet", hs_rises - b, 0);
        soft_rst = 1'b1; enable = 1'b1;
        b = hs_rises;
        repeat (40) @(negedge clk);
        chk("R9 soft reset holds", hs_rises - b, 0);

        for (int m = 0; m < 5; m++) run_mode(MODES[m]);
        run_mode(MODES[0]);

        // R10: mid-field change of the sync width is deferred to the next field
        b = vs_falls;
        while (vs_falls <= b) @(posedge clk);
        @(negedge clk); h_sync_len = HCW'(4);
        b = hs_falls;
        while (hs_falls <= b) @(posedge clk);
        chk("R10 width held this field", last_hs_w, HS);
        b = vs_falls;
        while (vs_falls <= b) @(posedge clk);
        chk("R10 width applied next field", last_hs_w, 4);

        @(negedge clk); enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 disable quiets hsync", hsync_o, 0);
        chk("R9 disable quiets de", de_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule